// File: doc/BRIEF.md
# Pipelined Data Tenure Ordering Controller

On a split-transaction pipelined bus, every address tenure that has been issued still owes a data tenure. This controller queues those owed data tenures. Each entry records whether it is a read or a write and carries a small tag. When the data bus is granted and the grant qualifies, the controller picks the tenure to run next. It then raises a one-cycle start pulse and presents the chosen tag and type. Those outputs stay put until the data-phase logic reports completion.

By default, tenures leave in the order their address tenures were issued. A write-first override can be sampled in the same cycle as a qualified grant. It lets the oldest queued write run ahead of older reads. The override never lets one write overtake another, and it has no effect when no write is queued. The completed entry is removed from wherever it sits, and the remaining entries keep their relative order.

Top module: `dto_ordering_ctrl`

## Requirements
- R1: After reset the queue is empty, `enq_ready` is 1 and `tenure_start` is 0.
- R2: When `write_first` is 0 at a qualified grant, the oldest queued entry is selected, whatever its type.
- R3: When `write_first` is 1 at a qualified grant and at least one write is queued, the oldest queued write is selected, even if reads are older.
- R4: When `write_first` is 1 at a qualified grant and no write is queued, the oldest entry (a read) is selected.
- R5: Writes always leave in the order they were enqueued, under any pattern of `write_first`.
- R6: `write_first` has no effect in any cycle without a qualified grant.
- R7: The queue holds 4 entries. `enq_ready` is 0 while it is full, and an `enq_valid` seen while full is dropped.
- R8: A qualified grant requires `dbus_grant`=1, a non-empty queue and no active tenure. Grants during an active tenure produce no start and leave the selection unchanged.
- R9: `tenure_start` goes high for exactly one cycle, in the cycle after the qualified grant edge. `sel_tag` and `sel_is_write` (1 = write) are valid from that cycle and stay stable until `tenure_done`.
- R10: `tenure_done` during an active tenure removes the selected entry. The remaining entries, including ones enqueued meanwhile, keep their relative order.
- R11: A grant while the queue is empty produces no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | An address tenure finished; queue its data tenure |
| enq_is_write | input | 1 | Type of the queued tenure: 1 = write, 0 = read |
| enq_tag | input | TAG_W | Tag of the queued tenure |
| enq_ready | output | 1 | Queue has room |
| dbus_grant | input | 1 | Data bus grant |
| write_first | input | 1 | Override: run the oldest write before older reads |
| tenure_done | input | 1 | The active data tenure has finished |
| tenure_start | output | 1 | One-cycle pulse: selected tenure begins |
| sel_tag | output | TAG_W | Tag of the selected tenure |
| sel_is_write | output | 1 | Type of the selected tenure |

## Verification
The hardest case to reach is a removal from the middle of the queue with newer entries behind it. Only the override can select a non-head entry, so the queue first has to hold reads in front of writes, and then the override has to coincide with a qualified grant. The bench sweeps every read/write mix of a full queue against every per-grant override pattern, so every removal position occurs. A directed case adds an enqueue during an active middle-slot tenure to show that the newcomer lands behind the survivors.

// File: rtl/dto_pkg.sv
package dto_pkg;
  localparam int MAX_SLOTS = 16;

  // Lowest set position of a mask; 0 when empty.
  function automatic int oldest_set(input logic [MAX_SLOTS-1:0] m);
    int r;
    r = 0;
    for (int i = MAX_SLOTS - 1; i >= 0; i--) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction

  // Slot to serve: oldest write on override when a write exists, else the head.
  function automatic int choose_slot(input logic [MAX_SLOTS-1:0] wmask,
                                     input logic override);
    if (override && (|wmask)) return oldest_set(wmask);
    return 0;
  endfunction
endpackage

// File: rtl/dto_queue.sv
module dto_queue #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic                   push_write,
  input  logic [TAG_W-1:0]       push_tag,
  input  logic                   pop,
  input  logic [IDX_W-1:0]       pop_idx,
  output logic [CNT_W-1:0]       count,
  output logic                   full,
  output logic                   empty,
  output logic [DEPTH-1:0]       write_mask,
  output logic [DEPTH*TAG_W-1:0] slot_tags
);
  logic [DEPTH-1:0] q_w, n_w;
  logic [TAG_W-1:0] q_t [DEPTH];
  logic [TAG_W-1:0] n_t [DEPTH];
  logic [CNT_W-1:0] cnt_left, n_count;
  logic             accept;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign accept = push && !full;

  always_comb begin
    cnt_left = count - CNT_W'(pop);
    for (int i = 0; i < DEPTH; i++) begin
      n_w[i] = q_w[i];
      n_t[i] = q_t[i];
      if (pop && (i >= int'(pop_idx)) && (i + 1 < DEPTH)) begin
        n_w[i] = q_w[i+1];
        n_t[i] = q_t[i+1];
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (accept && (i == int'(cnt_left))) begin
        n_w[i] = push_write;
        n_t[i] = push_tag;
      end
    end
    n_count = cnt_left + CNT_W'(accept);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      q_w   <= '0;
      for (int i = 0; i < DEPTH; i++) q_t[i] <= '0;
    end else begin
      count <= n_count;
      q_w   <= n_w;
      for (int i = 0; i < DEPTH; i++) q_t[i] <= n_t[i];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign write_mask[g] = q_w[g] && (CNT_W'(g) < count);
    assign slot_tags[g*TAG_W +: TAG_W] = q_t[g];
  end
endmodule

// File: rtl/dto_pick.sv
module dto_pick #(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] write_mask,
  input  logic             override,
  output logic [IDX_W-1:0] pick_idx,
  output logic             any_write
);
  import dto_pkg::*;
  logic [MAX_SLOTS-1:0] padded;

  always_comb begin
    padded = '0;
    padded[DEPTH-1:0] = write_mask;
    any_write = |write_mask;
    pick_idx  = IDX_W'(choose_slot(padded, override));
  end
endmodule

// File: rtl/dto_seq.sv
module dto_seq #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic             queue_empty,
  input  logic             done,
  input  logic [IDX_W-1:0] pick_idx,
  input  logic             pick_write,
  input  logic [TAG_W-1:0] pick_tag,
  output logic             active,
  output logic             qual_grant,
  output logic             pop,
  output logic [IDX_W-1:0] sel_idx,
  output logic             sel_write,
  output logic [TAG_W-1:0] sel_tag,
  output logic             start_pulse
);
  assign qual_grant = grant && !queue_empty && !active;
  assign pop        = done && active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      sel_idx     <= '0;
      sel_write   <= 1'b0;
      sel_tag     <= '0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= qual_grant;
      if (qual_grant) begin
        active    <= 1'b1;
        sel_idx   <= pick_idx;
        sel_write <= pick_write;
        sel_tag   <= pick_tag;
      end else if (pop) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dto_ordering_ctrl.sv
module dto_ordering_ctrl #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic             enq_is_write,
  input  logic [TAG_W-1:0] enq_tag,
  output logic             enq_ready,
  input  logic             dbus_grant,
  input  logic             write_first,
  input  logic             tenure_done,
  output logic             tenure_start,
  output logic [TAG_W-1:0] sel_tag,
  output logic             sel_is_write
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]       q_count;
  logic                   q_full, q_empty;
  logic [DEPTH-1:0]       write_mask;
  logic [DEPTH*TAG_W-1:0] slot_tags;
  logic [IDX_W-1:0]       pick_idx, sel_idx;
  logic                   any_write, active, qual_grant, pop;
  logic                   pick_write;
  logic [TAG_W-1:0]       pick_tag;

  assign enq_ready  = !q_full;
  assign pick_write = write_mask[pick_idx];
  assign pick_tag   = slot_tags[pick_idx*TAG_W +: TAG_W];

  dto_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(enq_valid), .push_write(enq_is_write), .push_tag(enq_tag),
    .pop(pop), .pop_idx(sel_idx),
    .count(q_count), .full(q_full), .empty(q_empty),
    .write_mask(write_mask), .slot_tags(slot_tags)
  );

  dto_pick #(.DEPTH(DEPTH)) u_pick (
    .write_mask(write_mask), .override(write_first),
    .pick_idx(pick_idx), .any_write(any_write)
  );

  dto_seq #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .grant(dbus_grant), .queue_empty(q_empty), .done(tenure_done),
    .pick_idx(pick_idx), .pick_write(pick_write), .pick_tag(pick_tag),
    .active(active), .qual_grant(qual_grant), .pop(pop),
    .sel_idx(sel_idx), .sel_write(sel_is_write), .sel_tag(sel_tag),
    .start_pulse(tenure_start)
  );
endmodule

// File: rtl/dto_checker.sv
module dto_checker #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             write_first,
  input logic             tenure_start,
  input logic [TAG_W-1:0] sel_tag,
  input logic             sel_is_write,
  input logic             active,
  input logic             any_write,
  input logic [CNT_W-1:0] q_count,
  input logic [IDX_W-1:0] sel_idx,
  input logic             pop
);
  p_head_without_override_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_start && !$past(write_first) |-> sel_idx == '0);

  p_override_takes_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_start && $past(write_first) && $past(any_write) |-> sel_is_write);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));

  p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == CNT_W'(DEPTH)) && !pop |=> q_count == CNT_W'(DEPTH));

  p_busy_blocks_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> !tenure_start);

  p_start_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_start |=> !tenure_start);

  p_sel_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active && !tenure_start |-> $stable(sel_tag) && $stable(sel_is_write));

  p_empty_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    q_count == '0 |=> !tenure_start);
endmodule

bind dto_ordering_ctrl dto_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .write_first(write_first),
  .tenure_start(tenure_start), .sel_tag(sel_tag), .sel_is_write(sel_is_write),
  .active(active), .any_write(any_write), .q_count(q_count),
  .sel_idx(sel_idx), .pop(pop)
);

// File: tb/sim_dto_ordering_ctrl.sv
module sim_dto_ordering_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0, enq_is_write = 1'b0;
  logic [1:0] enq_tag = '0;
  logic dbus_grant = 1'b0, write_first = 1'b0, tenure_done = 1'b0;
  logic enq_ready, tenure_start, sel_is_write;
  logic [1:0] sel_tag;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  int mq_w [4];
  int mq_t [4];
  int mcnt = 0;

  always #10 clk = ~clk;

  dto_ordering_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_is_write(enq_is_write),
    .enq_tag(enq_tag), .enq_ready(enq_ready), .dbus_grant(dbus_grant),
    .write_first(write_first), .tenure_done(tenure_done),
    .tenure_start(tenure_start), .sel_tag(sel_tag), .sel_is_write(sel_is_write)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enq(input int w, input int t);
    enq_valid = 1'b1; enq_is_write = w[0]; enq_tag = t[1:0];
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic do_grant(input int ov);
    dbus_grant = 1'b1; write_first = ov[0];
    @(negedge clk);
    dbus_grant = 1'b0; write_first = 1'b0;
  endtask

  task automatic finish_tenure();
    tenure_done = 1'b1;
    @(negedge clk);
    tenure_done = 1'b0;
  endtask

  function automatic int model_pick(input int ov);
    if (ov != 0)
      for (int i = 0; i < mcnt; i++) if (mq_w[i] != 0) return i;
    return 0;
  endfunction

  task automatic model_remove(input int idx);
    for (int i = idx; i < 3; i++) begin mq_w[i] = mq_w[i+1]; mq_t[i] = mq_t[i+1]; end
    mcnt--;
  endtask

  task automatic grant_expect(input string req, input int ov, input int etag, input int ew);
    do_grant(ov);
    chk(req, int'(tenure_start), 1);
    chk(req, int'(sel_tag), etag);
    chk(req, int'(sel_is_write), ew);
    @(negedge clk);
    chk("R9 pulse width", int'(tenure_start), 0);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired (all requirements)");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 start low", int'(tenure_start), 0);
    chk("R1 ready high", int'(enq_ready), 1);

    // R11: grant on an empty queue
    do_grant(1);
    chk("R11 empty grant", int'(tenure_start), 0);
    @(negedge clk);

    // R7: fill, then drop a fifth entry
    enq(0, 0); enq(1, 1); enq(0, 2);
    chk("R7 ready before full", int'(enq_ready), 1);
    enq(1, 3);
    chk("R7 ready when full", int'(enq_ready), 0);
    enq(1, 2);
    chk("R7 still full", int'(enq_ready), 0);
    // R6: override without grant does nothing; plain grant takes head
    write_first = 1'b1; @(negedge clk); write_first = 1'b0;
    chk("R6 no start without grant", int'(tenure_start), 0);
    grant_expect("R6 head after stray override", 0, 0, 0);
    // R8: grant with override while active is ignored
    do_grant(1);
    chk("R8 busy grant ignored", int'(tenure_start), 0);
    chk("R8 sel tag kept", int'(sel_tag), 0);
    @(negedge clk);
    chk("R9 sel held", int'(sel_is_write), 0);
    finish_tenure();
    grant_expect("R7 order after drop", 0, 1, 1); finish_tenure();
    grant_expect("R7 order after drop", 0, 2, 0); finish_tenure();
    grant_expect("R7 order after drop", 0, 3, 1); finish_tenure();
    do_grant(0);
    chk("R7 dropped entry absent", int'(tenure_start), 0);
    chk("R7 ready after drain", int'(enq_ready), 1);
    @(negedge clk);

    // R10: middle removal with an enqueue during the tenure
    enq(0, 0); enq(1, 1); enq(0, 2);
    grant_expect("R3 write jumps read", 1, 1, 1);
    enq(1, 3);
    finish_tenure();
    grant_expect("R10 head kept", 0, 0, 0); finish_tenure();
    grant_expect("R10 newer write", 1, 3, 1); finish_tenure();
    grant_expect("R10 last read", 0, 2, 0); finish_tenure();

    // Sweep: all type mixes x all per-grant override patterns
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        mcnt = 0;
        for (int i = 0; i < 4; i++) begin
          mq_w[i] = (p >> i) & 1; mq_t[i] = i; mcnt++;
          enq(mq_w[i], i);
        end
        for (int k = 0; k < 4; k++) begin
          int ov, idx;
          ov  = (m >> k) & 1;
          idx = model_pick(ov);
          if (ov == 0)                 grant_expect("R2 sweep in order", ov, mq_t[idx], mq_w[idx]);
          else if (mq_w[idx] != 0)     grant_expect("R3 R5 sweep oldest write", ov, mq_t[idx], mq_w[idx]);
          else                         grant_expect("R4 sweep no write pending", ov, mq_t[idx], mq_w[idx]);
          model_remove(idx);
          finish_tenure();
        end
        chk("R10 sweep drained", int'(enq_ready), 1);
      end
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule